// File: doc/BRIEF.md
# LFSR-Counted Video Timing Generator

This block produces the horizontal sync, vertical sync and active-video strobes for a raster display. It keeps no binary pixel or line counter. Each axis has a 16-bit linear-feedback shift register that starts from the all-ones seed. Every boundary of the raster is programmed as the LFSR state the register reaches after the intended number of steps from that seed. A match is a single 16-bit equality compare, and the next-state logic is one XOR gate deep, so the counters stay shallow at any raster size.

The host converts pixel and line counts into LFSR states and presents them on the boundary inputs. The boundaries are line end, sync start and end, and display start and end, on each axis. A pixel-clock enable advances the horizontal register. The vertical register moves once per completed line. Two mode inputs control the outputs: one blanks the picture, and the other powers the display down.

Top module: `lfsr_video_timing`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads both position registers with the count-0 state 0xFFFF. Each window flag is set to whether count 0 lies inside its window.
- R2: A step shifts the state left by one bit. The new bit 0 is the XOR of state bits 15, 4, 2 and 1. Count n is the state reached after n steps from 0xFFFF.
- R3: The horizontal register steps once per cycle with pix_en high. When it equals h_total_code, it reloads 0xFFFF instead of stepping. A line is therefore (horizontal end count + 1) enabled cycles long.
- R4: The vertical register steps once per completed line. When a line completes while it equals v_total_code, it reloads 0xFFFF. A frame is (vertical end count + 1) lines.
- R5: hsync is high (active high) while the horizontal count c satisfies start <= c < end. Here start and end are the counts encoded in h_sync_beg_code and h_sync_end_code.
- R6: vsync is high while the vertical count lies in the half-open window given by v_sync_beg_code and v_sync_end_code.
- R7: active is high only when the horizontal count is inside [h_disp_beg, h_disp_end) and the vertical count is inside [v_disp_beg, v_disp_end).
- R8: blank high forces active low and leaves hsync and vsync unchanged.
- R9: pwr_down high forces hsync, vsync and active all low.
- R10: A window whose start and end codes are equal never opens.
- R11: While pix_en is low, both position registers and all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel step enable |
| blank | input | 1 | Blank mode: active forced low |
| pwr_down | input | 1 | Power-down mode: all outputs low |
| h_total_code | input | 16 | Encoded horizontal end count (pixels per line − 1) |
| h_sync_beg_code | input | 16 | Encoded hsync start count |
| h_sync_end_code | input | 16 | Encoded hsync end count |
| h_disp_beg_code | input | 16 | Encoded horizontal display start |
| h_disp_end_code | input | 16 | Encoded horizontal display end |
| v_total_code | input | 16 | Encoded vertical end count |
| v_sync_beg_code | input | 16 | Encoded vsync start count |
| v_sync_end_code | input | 16 | Encoded vsync end count |
| v_disp_beg_code | input | 16 | Encoded vertical display start |
| v_disp_end_code | input | 16 | Encoded vertical display end |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Active-video strobe |

## Verification
The embedded properties run on every cycle. They check that the position registers freeze without an enable and reload the seed after an end match. They also check that neither register ever reaches the all-zero lock state, that window flags move only on a step, and that the blank and power-down overrides hold. Only the bench's scenarios can show that each window opens and closes at the right binary count. The same holds for the measured line and frame lengths, for an empty window staying shut, and for raster geometry staying correct under gapped enables. The bench shows these by comparing every cycle against a binary-count reference model that derives its codes from the step rule.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t LFSR_SEED = '1;
  // feedback taps: bits 15, 4, 2, 1
  localparam lfsr_t LFSR_TAPS = lfsr_t'(16'h8016);

  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction
endpackage

// File: rtl/lfsr_axis_counter.sv
module lfsr_axis_counter
  import lfsr_vtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  lfsr_t end_code,
  output lfsr_t state,
  output lfsr_t nxt,
  output logic  at_end
);
  assign at_end = (state == end_code);
  assign nxt    = at_end ? LFSR_SEED : lfsr_step(state);

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= LFSR_SEED;
    else if (adv) state <= nxt;
  end

  // R11
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  // R3
  reload_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_end) |=> (state == LFSR_SEED));
  // R2
  no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/lfsr_window.sv
module lfsr_window
  import lfsr_vtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  lfsr_t nxt,
  input  lfsr_t beg_code,
  input  lfsr_t end_code,
  output logic  open
);
  logic open_d;

  // end match has priority so that beg == end gives an empty window
  always_comb begin
    open_d = open;
    if (nxt == end_code)      open_d = 1'b0;
    else if (nxt == beg_code) open_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   open <= (LFSR_SEED == beg_code) && (LFSR_SEED != end_code);
    else if (adv) open <= open_d;
  end

  // R11
  window_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(open));
  // R10
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && beg_code == end_code && nxt == beg_code) |=> !open);
endmodule

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing
  import lfsr_vtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        blank,
  input  logic        pwr_down,
  input  logic [15:0] h_total_code,
  input  logic [15:0] h_sync_beg_code,
  input  logic [15:0] h_sync_end_code,
  input  logic [15:0] h_disp_beg_code,
  input  logic [15:0] h_disp_end_code,
  input  logic [15:0] v_total_code,
  input  logic [15:0] v_sync_beg_code,
  input  logic [15:0] v_sync_end_code,
  input  logic [15:0] v_disp_beg_code,
  input  logic [15:0] v_disp_end_code,
  output logic        hsync,
  output logic        vsync,
  output logic        active
);
  lfsr_t h_state, h_nxt, v_state, v_nxt;
  logic  h_at_end, v_at_end;
  logic  line_done, frame_done;
  logic  hs_open, hd_open, vs_open, vd_open;

  assign line_done  = pix_en & h_at_end;
  assign frame_done = line_done & v_at_end;

  lfsr_axis_counter u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(pix_en), .end_code(h_total_code),
    .state(h_state), .nxt(h_nxt), .at_end(h_at_end));

  lfsr_axis_counter u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv(line_done), .end_code(v_total_code),
    .state(v_state), .nxt(v_nxt), .at_end(v_at_end));

  lfsr_window u_hsync_win (
    .clk(clk), .rst_n(rst_n), .adv(pix_en), .nxt(h_nxt),
    .beg_code(h_sync_beg_code), .end_code(h_sync_end_code), .open(hs_open));

  lfsr_window u_hdisp_win (
    .clk(clk), .rst_n(rst_n), .adv(pix_en), .nxt(h_nxt),
    .beg_code(h_disp_beg_code), .end_code(h_disp_end_code), .open(hd_open));

  lfsr_window u_vsync_win (
    .clk(clk), .rst_n(rst_n), .adv(line_done), .nxt(v_nxt),
    .beg_code(v_sync_beg_code), .end_code(v_sync_end_code), .open(vs_open));

  lfsr_window u_vdisp_win (
    .clk(clk), .rst_n(rst_n), .adv(line_done), .nxt(v_nxt),
    .beg_code(v_disp_beg_code), .end_code(v_disp_end_code), .open(vd_open));

  assign hsync  = hs_open & ~pwr_down;
  assign vsync  = vs_open & ~pwr_down;
  assign active = hd_open & vd_open & ~blank & ~pwr_down;

  // R4
  frame_wraps_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (v_state == LFSR_SEED && h_state == LFSR_SEED));
  // R4
  vert_moves_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_done |=> $stable(v_state));
  // R9
  pwrdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!hsync && !vsync && !active));
  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !active);
endmodule

// File: tb/lfsr_video_timing_test.sv
module lfsr_video_timing_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pix_en = 1'b0, blank = 1'b0, pwr_down = 1'b0;
  logic [15:0] htc, hsb, hse, hdb, hde, vtc, vsb, vse, vdb, vde;
  logic hsync, vsync, active;

  int errors = 0, checks = 0;
  bit done = 0, cmp_on = 0;

  // model geometry, binary counts
  int m_htot, m_hsb, m_hse, m_hdb, m_hde, m_vend, m_vsb, m_vse, m_vdb, m_vde;
  int hc, vc;

  always #(CLK_P/2) clk = ~clk;

  lfsr_video_timing uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .blank(blank), .pwr_down(pwr_down),
    .h_total_code(htc), .h_sync_beg_code(hsb), .h_sync_end_code(hse),
    .h_disp_beg_code(hdb), .h_disp_end_code(hde),
    .v_total_code(vtc), .v_sync_beg_code(vsb), .v_sync_end_code(vse),
    .v_disp_beg_code(vdb), .v_disp_end_code(vde),
    .hsync(hsync), .vsync(vsync), .active(active));

  // host-side encoding (R2): n steps from the all-ones seed
  function automatic logic [15:0] enc(input int n);
    logic [15:0] v = 16'hFFFF;
    for (int k = 0; k < n; k++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
    return enc_ret(v);
  endfunction
  function automatic logic [15:0] enc_ret(input logic [15:0] v);
    return v;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (h=%0d v=%0d t=%0t)", req, act, exp, hc, vc, $time);
    end
  endtask

  // reference model (R3, R4)
  always @(posedge clk) begin
    if (!rst_n) begin hc = 0; vc = 0; end
    else if (pix_en) begin
      if (hc == m_htot - 1) begin
        hc = 0;
        vc = (vc == m_vend) ? 0 : vc + 1;
      end else hc = hc + 1;
    end
  end

  function automatic bit inw(input int c, input int b, input int e);
    return (c >= b) && (c < e);
  endfunction

  // per-cycle comparison; a wrong step rule (R2) shows as shifted windows
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(pwr_down ? "R9" : "R5", hsync, !pwr_down && inw(hc, m_hsb, m_hse));
      check(pwr_down ? "R9" : "R6", vsync, !pwr_down && inw(vc, m_vsb, m_vse));
      check(pwr_down ? "R9" : (blank ? "R8" : "R7"), active,
            !pwr_down && !blank && inw(hc, m_hdb, m_hde) && inw(vc, m_vdb, m_vde));
    end
  end

  task automatic geometry(input int ht, input int hs0, input int hs1, input int hd0,
                          input int hd1, input int vend, input int vs0, input int vs1,
                          input int vd0, input int vd1);
    m_htot = ht; m_hsb = hs0; m_hse = hs1; m_hdb = hd0; m_hde = hd1;
    m_vend = vend; m_vsb = vs0; m_vse = vs1; m_vdb = vd0; m_vde = vd1;
    htc = enc(ht - 1); hsb = enc(hs0); hse = enc(hs1); hdb = enc(hd0); hde = enc(hd1);
    vtc = enc(vend); vsb = enc(vs0); vse = enc(vs1); vdb = enc(vd0); vde = enc(vd1);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; pix_en = 0; blank = 0; pwr_down = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pix_en = (gap == 0) ? 1'b1 : ((i % gap) != 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int last_hs, last_vs, n_h, n_v, cyc;
    logic hs_q, vs_q, ac_q, hs_seen;
    geometry(20, 1, 4, 6, 18, 10, 0, 2, 3, 9);
    do_reset();
    @(negedge clk);
    // R1: count 0 -> hsync low, vsync high (window starts at 0), active low
    check("R1", hsync, 1'b0);
    check("R1", vsync, 1'b1);
    check("R1", active, 1'b0);
    cmp_on = 1;

    // R3/R4 measured independently with a steady enable
    last_hs = -1; last_vs = -1; n_h = 0; n_v = 0; cyc = 0; hs_q = hsync; vs_q = vsync;
    pix_en = 1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk); cyc++;
      if (hsync && !hs_q) begin
        if (last_hs >= 0) begin n_h++; check("R3", (cyc - last_hs) == 20, 1'b1); end
        last_hs = cyc;
      end
      if (vsync && !vs_q) begin
        if (last_vs >= 0) begin n_v++; check("R4", (cyc - last_vs) == 220, 1'b1); end
        last_vs = cyc;
      end
      hs_q = hsync; vs_q = vsync;
    end
    check("R3", n_h > 10, 1'b1);
    check("R4", n_v >= 2, 1'b1);

    // gapped enable
    run(900, 3);

    // R11: freeze the enable and hold outputs
    @(posedge clk); #1 pix_en = 0;
    @(negedge clk); hs_q = hsync; vs_q = vsync; ac_q = active;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R11", {hsync, vsync, active} == {hs_q, vs_q, ac_q}, 1'b1);
    end

    // R8: blank toggling
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 blank = ~blank; pix_en = 1;
      run(37, 0);
    end
    @(posedge clk); #1 blank = 0;

    // R9: power down
    @(posedge clk); #1 pwr_down = 1;
    run(250, 0);
    @(posedge clk); #1 pwr_down = 0;
    run(100, 0);

    // R10: hsync start equals end
    cmp_on = 0;
    geometry(20, 3, 3, 6, 18, 10, 0, 2, 3, 9);
    do_reset();
    cmp_on = 1;
    hs_seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1 pix_en = 1;
      @(negedge clk); hs_seen = hs_seen | hsync;
    end
    check("R10", hs_seen, 1'b0);

    // second geometry, gapped enable
    cmp_on = 0;
    geometry(32, 1, 6, 8, 30, 6, 0, 1, 1, 5);
    do_reset();
    cmp_on = 1;
    run(1200, 4);
    run(400, 0);

    cmp_on = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule